// File: doc/BRIEF.md
# Multichannel configuration register bank

This block is the byte-wide configuration register file of an eight-channel converter. It also covers two clock-output channels. Software reaches it through a plain address, data and strobe port that stands in for a serial control interface. Each of the ten channels keeps two copies of its settings: a 3-bit power-mode code and a duty-cycle-stabilizer enable. A write fills the master copy. Only the slave copy drives the datapath outputs.

A pair of selection registers decides which channels' master copies a per-channel write reaches. A one-shot transfer command copies every master into its slave on a single edge. That lets software stage settings channel by channel and then apply them to all channels at once. A port-configuration byte carries a bit-order flag and a soft-reset request. Each of the two appears in mirrored bit positions, so the byte decodes the same whichever way it was shifted in. Two read-only registers give a chip identifier and a speed-grade code.

The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `mcfg_regbank`

## Requirements
- R1: After reset, the registers read as follows: 0x00 reads 0x18, 0x04 reads 0x0F, 0x05 reads 0x0F, 0x08 reads 0x00, 0x09 reads 0x01 and 0xFF reads 0x00. Every slave starts at power mode 000 with the stabilizer enabled (`ch_dcs_en` all ones), and `lsb_first` is 0.
- R2: Address 0x01 always reads the parameter CHIP_ID (default 0x08), and writes to it have no effect.
- R3: Address 0x02 reads {0, GRADE_CODE[2:0], 0000}, where 000 is the faster grade and 001 the slower. Writes to it have no effect.
- R4: Channel selection comes from two registers. Address 0x05 bits [3:0] select data channels 0–3 (A–D), bit 4 selects clock channel 8 and bit 5 selects clock channel 9. Address 0x04 bits [3:0] select data channels 4–7 (E–H). Bits above these fields read as 0.
- R5: A write to 0x08 or 0x09 updates the master copy of every currently selected channel and of no other. No slave output changes without a transfer.
- R6: Writing 0xFF with bit 0 set copies all ten masters into the slaves together. The new values are visible on `ch_pwr_mode` and `ch_dcs_en` after the second rising edge counted from the edge that takes the write, and not before.
- R7: Bits [2:0] of 0x08 hold the power mode: 000 run, 001 full power-down, 010 standby, 011 reset. Bit 0 of 0x09 holds the stabilizer enable. Other bits of these registers are dropped on write.
- R8: The transfer bit and the soft-reset bits read as 1 only in the single cycle after the write that set them, and read as 0 from then on.
- R9: In byte 0x00, the bit-order flag is bit 6 OR bit 1, and the soft-reset request is bit 5 OR bit 2. A read returns {0, lsb, srst, 1, 1, srst, lsb, 0}. The output `lsb_first` follows the stored flag.
- R10: One edge after a soft-reset write, all masters, slaves, the selection registers and the bit-order flag return to their defaults. A write arriving in that cycle is dropped, and 0x01 and 0x02 are unchanged.
- R11: A read of 0x08 or 0x09 returns the master copy of the lowest-numbered selected channel, in the order A..H, then channel 8, then channel 9. With no channel selected the read returns 0x00.
- R12: Read data is registered. It appears on `bus_rdata` after the edge that samples `bus_rd`, and holds when no read is made. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lsb_first | output | 1 | Stored bit-order flag |
| ch_pwr_mode | output | 30 | Slave power mode, 3 bits per channel, channel 0 in the low bits |
| ch_dcs_en | output | 10 | Slave stabilizer enable per channel |

## Verification
A master write takes effect on the edge that samples it, and a read returns its value one edge later. The bench therefore checks read data at the falling edge that follows the sampling edge. A transfer or soft reset first sets a pending flag on the write edge and acts one edge after that. The bench checks the slave outputs at the falling edge between those two edges, where they must still hold their old values. It checks them again one edge later, where they must carry the new ones. A read issued in the pending cycle returns the flag as 1, and a read one cycle later returns it as 0. The bench reads the flag at both points.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int unsigned DW          = 8;
  localparam int unsigned AW          = 8;
  localparam int unsigned NUM_DATA_CH = 8;
  localparam int unsigned NUM_CLK_CH  = 2;
  localparam int unsigned NUM_CH      = NUM_DATA_CH + NUM_CLK_CH;
  localparam int unsigned MODE_W      = 3;
  localparam int unsigned HALF_W      = NUM_DATA_CH / 2;
  localparam int unsigned IDX_HI_W    = HALF_W;
  localparam int unsigned IDX_LO_W    = HALF_W + NUM_CLK_CH;

  localparam logic [AW-1:0] A_PORT   = 8'h00;
  localparam logic [AW-1:0] A_ID     = 8'h01;
  localparam logic [AW-1:0] A_GRADE  = 8'h02;
  localparam logic [AW-1:0] A_IDX_HI = 8'h04;
  localparam logic [AW-1:0] A_IDX_LO = 8'h05;
  localparam logic [AW-1:0] A_PWR    = 8'h08;
  localparam logic [AW-1:0] A_CLKOPT = 8'h09;
  localparam logic [AW-1:0] A_XFER   = 8'hFF;

  localparam logic [IDX_HI_W-1:0] IDX_HI_DEF = '1;
  localparam logic [IDX_LO_W-1:0] IDX_LO_DEF = {{NUM_CLK_CH{1'b0}}, {HALF_W{1'b1}}};

  typedef struct packed {
    logic [MODE_W-1:0] pwr;
    logic              dcs;
  } chan_cfg_t;

  localparam chan_cfg_t CHAN_DEF = '{pwr: '0, dcs: 1'b1};
endpackage

// File: rtl/mcfg_rst_sync.sv
module mcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mcfg_port_ctrl.sv
module mcfg_port_ctrl
  import mcfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic                lsb_q,
  output logic                srst_q,
  output logic                xfer_q,
  output logic [IDX_HI_W-1:0] idx_hi_q,
  output logic [IDX_LO_W-1:0] idx_lo_q,
  output logic [NUM_CH-1:0]   chan_sel
);
  logic                lsb_d, srst_d, xfer_d;
  logic [IDX_HI_W-1:0] idx_hi_d;
  logic [IDX_LO_W-1:0] idx_lo_d;
  logic                unused_bits;

  assign unused_bits = ^{wdata[7], wdata[4:3]};

  always_comb begin
    lsb_d    = lsb_q;
    srst_d   = 1'b0;
    xfer_d   = 1'b0;
    idx_hi_d = idx_hi_q;
    idx_lo_d = idx_lo_q;
    if (srst_q) begin
      lsb_d    = 1'b0;
      idx_hi_d = IDX_HI_DEF;
      idx_lo_d = IDX_LO_DEF;
    end else if (wr) begin
      unique case (addr)
        A_PORT: begin
          lsb_d  = wdata[6] | wdata[1];
          srst_d = wdata[5] | wdata[2];
        end
        A_IDX_HI: idx_hi_d = wdata[IDX_HI_W-1:0];
        A_IDX_LO: idx_lo_d = wdata[IDX_LO_W-1:0];
        A_XFER:   xfer_d   = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q    <= 1'b0;
      srst_q   <= 1'b0;
      xfer_q   <= 1'b0;
      idx_hi_q <= IDX_HI_DEF;
      idx_lo_q <= IDX_LO_DEF;
    end else begin
      lsb_q    <= lsb_d;
      srst_q   <= srst_d;
      xfer_q   <= xfer_d;
      idx_hi_q <= idx_hi_d;
      idx_lo_q <= idx_lo_d;
    end
  end

  assign chan_sel = {idx_lo_q[IDX_LO_W-1:HALF_W], idx_hi_q, idx_lo_q[HALF_W-1:0]};

  AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_q && !(wr && addr == A_XFER && wdata[0])) |=> !xfer_q); // R8
  AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && !lsb_q && idx_hi_q == IDX_HI_DEF && idx_lo_q == IDX_LO_DEF)); // R10
endmodule

// File: rtl/mcfg_chan_slice.sv
module mcfg_chan_slice
  import mcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_pwr,
  input  logic              wr_clk,
  input  logic [MODE_W-1:0] pwr_wdata,
  input  logic              dcs_wdata,
  input  logic              xfer_go,
  input  logic              srst_go,
  output chan_cfg_t         mst_q,
  output chan_cfg_t         slv_q
);
  chan_cfg_t mst_d, slv_d;

  always_comb begin
    mst_d = mst_q;
    slv_d = slv_q;
    if (srst_go) begin
      mst_d = CHAN_DEF;
      slv_d = CHAN_DEF;
    end else begin
      if (sel && wr_pwr) mst_d.pwr = pwr_wdata;
      if (sel && wr_clk) mst_d.dcs = dcs_wdata;
      if (xfer_go)       slv_d     = mst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= CHAN_DEF;
      slv_q <= CHAN_DEF;
    end else begin
      mst_q <= mst_d;
      slv_q <= slv_d;
    end
  end

  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !srst_go) |=> $stable(mst_q)); // R5
  AST_SLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_go && !srst_go) |=> $stable(slv_q)); // R5
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !srst_go) |=> slv_q == $past(mst_q)); // R6
  AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    srst_go |=> (mst_q == CHAN_DEF && slv_q == CHAN_DEF)); // R10
endmodule

// File: rtl/mcfg_read_mux.sv
module mcfg_read_mux
  import mcfg_pkg::*;
#(
  parameter logic [DW-1:0] CHIP_ID    = 8'h08,
  parameter logic [2:0]    GRADE_CODE = 3'b000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd,
  input  logic [AW-1:0]              addr,
  input  logic                       lsb_q,
  input  logic                       srst_q,
  input  logic                       xfer_q,
  input  logic [IDX_HI_W-1:0]        idx_hi_q,
  input  logic [IDX_LO_W-1:0]        idx_lo_q,
  input  logic [NUM_CH-1:0]          chan_sel,
  input  chan_cfg_t [NUM_CH-1:0]     mst_all,
  output logic [DW-1:0]              rdata_q
);
  chan_cfg_t     pick;
  logic          found;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_d;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_sel[i] && !found) begin
        found = 1'b1;
        pick  = mst_all[i];
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_PORT:   rd_val = {1'b0, lsb_q, srst_q, 1'b1, 1'b1, srst_q, lsb_q, 1'b0};
      A_ID:     rd_val = CHIP_ID;
      A_GRADE:  rd_val = {1'b0, GRADE_CODE, 4'b0000};
      A_IDX_HI: rd_val = {{(DW-IDX_HI_W){1'b0}}, idx_hi_q};
      A_IDX_LO: rd_val = {{(DW-IDX_LO_W){1'b0}}, idx_lo_q};
      A_PWR:    rd_val = found ? {{(DW-MODE_W){1'b0}}, pick.pwr} : '0;
      A_CLKOPT: rd_val = found ? {{(DW-1){1'b0}}, pick.dcs} : '0;
      A_XFER:   rd_val = {{(DW-1){1'b0}}, xfer_q};
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_ID) |=> rdata_q == CHIP_ID); // R2
  AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == A_PWR || addr == A_CLKOPT) && chan_sel == '0) |=> rdata_q == '0); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q)); // R12
endmodule

// File: rtl/mcfg_regbank.sv
module mcfg_regbank
  import mcfg_pkg::*;
#(
  parameter logic [DW-1:0] CHIP_ID    = 8'h08,
  parameter logic [2:0]    GRADE_CODE = 3'b000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     lsb_first,
  output logic [NUM_CH*MODE_W-1:0] ch_pwr_mode,
  output logic [NUM_CH-1:0]        ch_dcs_en
);
  logic                  rst_sync_n;
  logic                  srst_go, xfer_go;
  logic [IDX_HI_W-1:0]   idx_hi_q;
  logic [IDX_LO_W-1:0]   idx_lo_q;
  logic [NUM_CH-1:0]     chan_sel;
  logic                  wr_pwr, wr_clk;
  chan_cfg_t [NUM_CH-1:0] mst_all;
  chan_cfg_t [NUM_CH-1:0] slv_all;

  mcfg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  mcfg_port_ctrl i_port_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .lsb_q    (lsb_first),
    .srst_q   (srst_go),
    .xfer_q   (xfer_go),
    .idx_hi_q (idx_hi_q),
    .idx_lo_q (idx_lo_q),
    .chan_sel (chan_sel)
  );

  assign wr_pwr = bus_wr && (bus_addr == A_PWR);
  assign wr_clk = bus_wr && (bus_addr == A_CLKOPT);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    mcfg_chan_slice i_slice (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel       (chan_sel[g]),
      .wr_pwr    (wr_pwr),
      .wr_clk    (wr_clk),
      .pwr_wdata (bus_wdata[MODE_W-1:0]),
      .dcs_wdata (bus_wdata[0]),
      .xfer_go   (xfer_go),
      .srst_go   (srst_go),
      .mst_q     (mst_all[g]),
      .slv_q     (slv_all[g])
    );
    assign ch_pwr_mode[g*MODE_W +: MODE_W] = slv_all[g].pwr;
    assign ch_dcs_en[g]                    = slv_all[g].dcs;
  end

  mcfg_read_mux #(
    .CHIP_ID    (CHIP_ID),
    .GRADE_CODE (GRADE_CODE)
  ) i_read_mux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .lsb_q    (lsb_first),
    .srst_q   (srst_go),
    .xfer_q   (xfer_go),
    .idx_hi_q (idx_hi_q),
    .idx_lo_q (idx_lo_q),
    .chan_sel (chan_sel),
    .mst_all  (mst_all),
    .rdata_q  (bus_rdata)
  );
endmodule

// File: tb/test_mcfg_regbank.sv
module test_mcfg_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr, bus_wdata;
  logic [7:0]  bus_rdata;
  logic        lsb_first;
  logic [29:0] ch_pwr_mode;
  logic [9:0]  ch_dcs_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0] m_pwr [10];
  logic       m_dcs [10];
  logic [2:0] s_pwr [10];
  logic       s_dcs [10];
  logic [3:0] idx_hi;
  logic [5:0] idx_lo;
  logic       m_lsb;

  mcfg_regbank i_mcfg_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lsb_first(lsb_first), .ch_pwr_mode(ch_pwr_mode), .ch_dcs_en(ch_dcs_en)
  );

  always #2.5 clk = ~clk;

  function automatic logic [9:0] msel();
    return {idx_lo[5:4], idx_hi, idx_lo[3:0]};
  endfunction

  function automatic logic [7:0] exp_ch_read(input bit want_dcs);
    logic [9:0] s = msel();
    for (int i = 0; i < 10; i++)
      if (s[i]) return want_dcs ? {7'b0, m_dcs[i]} : {5'b0, m_pwr[i]};
    return 8'h00;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 10; i++) begin
      m_pwr[i] = 3'b000; m_dcs[i] = 1'b1; s_pwr[i] = 3'b000; s_dcs[i] = 1'b1;
    end
    idx_hi = 4'hF; idx_lo = 6'h0F; m_lsb = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    logic [29:0] ep;
    logic [9:0]  ed;
    for (int i = 0; i < 10; i++) begin
      ep[i*3 +: 3] = s_pwr[i];
      ed[i]        = s_dcs[i];
    end
    chk({req, " pwr outputs"}, {2'b0, ch_pwr_mode}, {2'b0, ep});
    chk({req, " dcs outputs"}, {22'b0, ch_dcs_en}, {22'b0, ed});
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [9:0] s = msel();
    wr_raw(a, d);
    case (a)
      8'h00: m_lsb  = d[6] | d[1];
      8'h04: idx_hi = d[3:0];
      8'h05: idx_lo = d[5:0];
      8'h08: for (int i = 0; i < 10; i++) if (s[i]) m_pwr[i] = d[2:0];
      8'h09: for (int i = 0; i < 10; i++) if (s[i]) m_dcs[i] = d[0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, {24'b0, bus_rdata}, {24'b0, exp});
  endtask

  task automatic do_xfer();
    wr_raw(8'hFF, 8'h01);
    chk_out("R6 before copy edge");
    rd_chk(8'hFF, 8'h01, "R8 transfer bit pending");
    for (int i = 0; i < 10; i++) begin s_pwr[i] = m_pwr[i]; s_dcs[i] = m_dcs[i]; end
    chk_out("R6 after copy edge");
    rd_chk(8'hFF, 8'h00, "R8 transfer bit cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    model_defaults();
    repeat (3) @(negedge clk);
    chk_out("R1 outputs in reset");
    chk("R1 lsb_first in reset", {31'b0, lsb_first}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd_chk(8'h00, 8'h18, "R1 port byte");
    rd_chk(8'h04, 8'h0F, "R1 index E-H");
    rd_chk(8'h05, 8'h0F, "R1 index A-D");
    rd_chk(8'h08, 8'h00, "R1 power mode");
    rd_chk(8'h09, 8'h01, "R1 stabilizer");
    rd_chk(8'hFF, 8'h00, "R1 transfer");

    // R2 / R3 read-only
    wr_raw(8'h01, 8'hFF);
    rd_chk(8'h01, 8'h08, "R2 chip id after write");
    wr_raw(8'h02, 8'hFF);
    rd_chk(8'h02, 8'h00, "R3 grade after write");

    // R12 unmapped and hold
    rd_chk(8'h03, 8'h00, "R12 unmapped 0x03");
    rd_chk(8'h0D, 8'h00, "R12 unmapped 0x0D");
    rd_chk(8'h01, 8'h08, "R12 read id");
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", {24'b0, bus_rdata}, 32'h08);

    // R9 mirrored port byte
    wr(8'h00, 8'h02);
    chk("R9 lsb via bit1", {31'b0, lsb_first}, 32'd1);
    rd_chk(8'h00, 8'h5A, "R9 read mirrored");
    wr(8'h00, 8'h00);
    rd_chk(8'h00, 8'h18, "R9 cleared");
    wr(8'h00, 8'h40);
    chk("R9 lsb via bit6", {31'b0, lsb_first}, 32'd1);

    // R4 R5 R6 R7 R11 sweep over every selection pattern
    for (int m = 0; m < 1024; m++) begin
      logic [9:0] mm = m[9:0];
      logic [2:0] pv = 3'((m * 5 + 3) % 8);
      logic       dv = mm[0] ^ mm[5];
      wr(8'h04, {4'hA, mm[7:4]});
      wr(8'h05, {2'b10, mm[9:8], mm[3:0]});
      rd_chk(8'h04, {4'h0, mm[7:4]}, "R4 index E-H field");
      rd_chk(8'h05, {2'b00, mm[9:8], mm[3:0]}, "R4 index A-D and clock field");
      wr(8'h08, {5'b10110, pv});
      wr(8'h09, {7'h2A, dv});
      rd_chk(8'h08, exp_ch_read(1'b0), "R11 R7 power mode read");
      rd_chk(8'h09, exp_ch_read(1'b1), "R11 R7 stabilizer read");
      chk_out("R5 no slave change before transfer");
      if (mm[1:0] == 2'b01 || m == 1023) do_xfer();
    end

    // R10 soft reset via bit 2, with pending read-back (R8)
    wr_raw(8'h00, 8'h04);
    rd_chk(8'h00, 8'h3C, "R8 soft-reset bits pending");
    model_defaults();
    chk_out("R10 slaves default");
    rd_chk(8'h00, 8'h18, "R8 R10 port byte after soft reset");
    rd_chk(8'h04, 8'h0F, "R10 index E-H");
    rd_chk(8'h05, 8'h0F, "R10 index A-D");
    rd_chk(8'h09, 8'h01, "R10 stabilizer master");
    rd_chk(8'h01, 8'h08, "R10 chip id kept");

    // R10 soft reset via bit 5, write in pending cycle dropped
    wr(8'h05, 8'h3F);
    wr(8'h08, 8'h05);
    do_xfer();
    wr_raw(8'h00, 8'h20);
    wr_raw(8'h08, 8'h07);
    model_defaults();
    chk_out("R10 slaves default second");
    rd_chk(8'h08, 8'h00, "R10 write in pending cycle dropped");
    chk("R10 lsb cleared", {31'b0, lsb_first}, 32'd0);

    // R11 no channel selected
    wr(8'h04, 8'h00);
    wr(8'h05, 8'h00);
    rd_chk(8'h08, 8'h00, "R11 none selected power");
    rd_chk(8'h09, 8'h00, "R11 none selected stabilizer");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule